// File: doc/BRIEF.md
# Cut-Through Packet Transmit FIFO

This block buffers packets between a user streaming source and a line-side transmitter. The user pushes 32-bit words with start, end and empty-byte markers over a valid/ready interface. The line side pulls words out as soon as the stored fill reaches a programmable start level (cut-through). When that level is zero, it waits for a whole packet (store-and-forward). Each stored word keeps its sop, eop and 2-bit empty count next to the data.

Four levels are held in registers written through a small write port: start level, throttle level, space-warning level and abort level. A throttle flag drops ready to the user when free space runs low, sized for a ready latency of zero or one. A warning flag reports shrinking free space. If a packet in flight drains to the abort level before its end word has arrived, the block closes it with an error beat. It then discards the rest of that packet as the user writes it, so the line never underflows.

Top module: `pkt_tx_fifo`

## Requirements
- R1: After reset the FIFO is empty: out_valid=0, out_err=0, almost_full=0, space_warn=0 and in_ready=1.
- R2: With start level 0 (store-and-forward), out_valid stays 0 until the eop word of the head packet is stored.
- R3: With a nonzero start level, a packet with no stored eop is offered (out_valid=1, out_sop=1) once the fill is at least the start level, and not before.
- R4: Words leave in write order with their data, sop and eop; out_empty equals the written empty count on eop beats and is 0 on every other beat.
- R5: almost_full=1 and in_ready=0 whenever free space (DEPTH minus fill) is at or below the throttle level; with READY_LAT=0 a beat offered while in_ready=0 is not stored.
- R6: space_warn=1 exactly when free space is below the space-warning level.
- R7: While a started packet has no stored eop and the fill is at or below a nonzero abort level, the beat on the output carries out_eop=1 and out_err=1; after it is taken, every remaining word of that packet up to and including its eop is discarded without being offered.
- R8: If the start level does not exceed the abort level, a cut-through packet is aborted on its first beat (out_sop=1, out_eop=1, out_err=1).
- R9: With READY_LAT=1 a beat is stored when in_valid is high and in_ready was high in the previous cycle.
- R10: Packets written back to back (new sop on the beat after an eop) come out as separate, intact packets.
- R11: Level register writes take effect on the cycle after the write edge; cfg_wr_addr selects 0 start, 1 throttle, 2 space-warning, 3 abort. Reset defaults are 16, READY_LAT+3, DEPTH-16 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Level register write strobe |
| cfg_wr_addr | input | 2 | Level register select |
| cfg_wr_data | input | CNT_W (7) | Level value |
| in_valid | input | 1 | User beat valid |
| in_ready | output | 1 | Ready to user (low while throttled) |
| in_sop | input | 1 | User start of packet |
| in_eop | input | 1 | User end of packet |
| in_empty | input | 2 | Unused bytes in the eop word |
| in_data | input | 32 | User data word |
| almost_full | output | 1 | Free space at or below throttle level |
| space_warn | output | 1 | Free space below warning level |
| out_valid | output | 1 | Line-side beat valid |
| out_ready | input | 1 | Line side takes the beat |
| out_sop | output | 1 | Line-side start of packet |
| out_eop | output | 1 | Line-side end of packet (also on abort) |
| out_empty | output | 2 | Unused bytes on eop beat |
| out_data | output | 32 | Line-side data word |
| out_err | output | 1 | Final beat of an aborted packet |

## Verification
The hardest state to reach is the abort path: the line side must start a packet in cut-through mode, then drain it faster than the user fills it until the fill meets the abort level with no eop stored. The stimulus gets there by writing a partial packet up to the start level with the line side stalled, then releasing the line side alone. It then feeds the packet's tail and a fresh packet to show the tail is swallowed and the next packet survives. The latency-one throttle is reached on a second instance with the throttle level raised so that ready falls after two words.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
    localparam int WORD_W = 32;
    localparam int SYM_W  = 2;

    // one stored beat
    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [SYM_W-1:0]  empty;
        logic [WORD_W-1:0] data;
    } beat_t;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_BODY = 2'd1,
        RD_DROP = 2'd2
    } rd_state_t;

    // level register selects
    localparam int LVL_START    = 0;
    localparam int LVL_THROTTLE = 1;
    localparam int LVL_WARN     = 2;
    localparam int LVL_ABORT    = 3;
    localparam int LVL_NUM      = 4;

    function automatic int level_default(input int idx, input int depth, input int lat);
        case (idx)
            LVL_START:    return 16;
            LVL_THROTTLE: return lat + 3;
            LVL_WARN:     return depth - 16;
            default:      return 8;
        endcase
    endfunction
endpackage

// File: rtl/ptf_cfg_regs.sv
module ptf_cfg_regs
    import ptf_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int READY_LAT = 0,
    parameter int CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] start_lvl,
    output logic [CNT_W-1:0] throttle_lvl,
    output logic [CNT_W-1:0] warn_lvl,
    output logic [CNT_W-1:0] abort_lvl
);
    logic [CNT_W-1:0] lvl [LVL_NUM];

    for (genvar g = 0; g < LVL_NUM; g++) begin : g_lvl
        localparam logic [CNT_W-1:0] DEF = CNT_W'(level_default(g, DEPTH, READY_LAT));
        always_ff @(posedge clk) begin
            if (rst)
                lvl[g] <= DEF;
            else if (wr_en && wr_addr == 2'(g))
                lvl[g] <= wr_data;
        end
    end

    assign start_lvl    = lvl[LVL_START];
    assign throttle_lvl = lvl[LVL_THROTTLE];
    assign warn_lvl     = lvl[LVL_WARN];
    assign abort_lvl    = lvl[LVL_ABORT];
endmodule

// File: rtl/ptf_store.sv
module ptf_store
    import ptf_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  beat_t            push_beat,
    input  logic             pop,
    output beat_t            head,
    output logic [CNT_W-1:0] fill,
    output logic [CNT_W-1:0] eop_cnt
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    beat_t             mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_beat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            fill    <= '0;
            eop_cnt <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            fill    <= fill + CNT_W'(push) - CNT_W'(pop);
            eop_cnt <= eop_cnt + CNT_W'(push && push_beat.eop) - CNT_W'(pop && head.eop);
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/ptf_wr_ctrl.sv
module ptf_wr_ctrl #(
    parameter int DEPTH     = 64,
    parameter int READY_LAT = 0,
    parameter int CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] throttle_lvl,
    input  logic [CNT_W-1:0] warn_lvl,
    output logic             in_ready,
    output logic             almost_full,
    output logic             space_warn,
    output logic             accept
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_words;
    logic             grant;

    assign free_words  = DEPTH_C - fill;
    assign almost_full = free_words <= throttle_lvl;
    assign space_warn  = free_words < warn_lvl;
    assign in_ready    = !almost_full;

    if (READY_LAT == 0) begin : g_lat0
        assign grant = in_ready;
    end else begin : g_lat1
        logic rdy_q;
        always_ff @(posedge clk) begin
            if (rst) rdy_q <= 1'b0;
            else     rdy_q <= in_ready;
        end
        assign grant = rdy_q;
    end

    // a full store never takes another word
    assign accept = in_valid && grant && (fill != DEPTH_C);
endmodule

// File: rtl/ptf_rd_ctrl.sv
module ptf_rd_ctrl
    import ptf_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_t             head,
    input  logic [CNT_W-1:0]  fill,
    input  logic [CNT_W-1:0]  eop_cnt,
    input  logic [CNT_W-1:0]  start_lvl,
    input  logic [CNT_W-1:0]  abort_lvl,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [SYM_W-1:0]  out_empty,
    output logic [WORD_W-1:0] out_data,
    output logic              out_err,
    output logic              pop
);
    rd_state_t st;
    logic have, complete, start_ok, active, cut, take;

    assign have     = fill != '0;
    assign complete = eop_cnt != '0;
    assign start_ok = complete || (start_lvl != '0 && fill >= start_lvl);
    assign active   = (st == RD_BODY) || (st == RD_IDLE && start_ok);
    assign cut      = active && have && !complete && abort_lvl != '0 && fill <= abort_lvl;

    assign out_valid = active && have;
    assign out_sop   = out_valid && head.sop;
    assign out_eop   = out_valid && (head.eop || cut);
    assign out_err   = out_valid && cut;
    assign out_empty = (out_valid && head.eop && !cut) ? head.empty : '0;
    assign out_data  = out_valid ? head.data : '0;

    assign take = out_valid && out_ready;
    assign pop  = take || (st == RD_DROP && have);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= RD_IDLE;
        end else begin
            case (st)
                RD_IDLE, RD_BODY: begin
                    if (take) begin
                        if (cut)           st <= RD_DROP;
                        else if (head.eop) st <= RD_IDLE;
                        else               st <= RD_BODY;
                    end
                end
                RD_DROP: begin
                    if (have && head.eop) st <= RD_IDLE;
                end
                default: st <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pkt_tx_fifo.sv
module pkt_tx_fifo
    import ptf_pkg::*;
#(
    parameter  int DEPTH     = 64,
    parameter  int READY_LAT = 0,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_addr,
    input  logic [CNT_W-1:0]  cfg_wr_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [SYM_W-1:0]  in_empty,
    input  logic [WORD_W-1:0] in_data,
    output logic              almost_full,
    output logic              space_warn,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [SYM_W-1:0]  out_empty,
    output logic [WORD_W-1:0] out_data,
    output logic              out_err
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic [CNT_W-1:0] start_lvl, throttle_lvl, warn_lvl, abort_lvl;
    logic [CNT_W-1:0] fill_cnt, eop_cnt;
    logic             accept, pop;
    beat_t            wr_beat, head;

    assign wr_beat = '{sop: in_sop, eop: in_eop, empty: in_empty, data: in_data};

    ptf_cfg_regs #(.DEPTH(DEPTH), .READY_LAT(READY_LAT), .CNT_W(CNT_W)) cfg_i (
        .clk(clk), .rst(rst),
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
        .start_lvl(start_lvl), .throttle_lvl(throttle_lvl),
        .warn_lvl(warn_lvl), .abort_lvl(abort_lvl)
    );

    ptf_wr_ctrl #(.DEPTH(DEPTH), .READY_LAT(READY_LAT), .CNT_W(CNT_W)) wr_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fill(fill_cnt),
        .throttle_lvl(throttle_lvl), .warn_lvl(warn_lvl),
        .in_ready(in_ready), .almost_full(almost_full),
        .space_warn(space_warn), .accept(accept)
    );

    ptf_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) store_i (
        .clk(clk), .rst(rst), .push(accept), .push_beat(wr_beat),
        .pop(pop), .head(head), .fill(fill_cnt), .eop_cnt(eop_cnt)
    );

    ptf_rd_ctrl #(.CNT_W(CNT_W)) rd_i (
        .clk(clk), .rst(rst), .head(head), .fill(fill_cnt), .eop_cnt(eop_cnt),
        .start_lvl(start_lvl), .abort_lvl(abort_lvl), .out_ready(out_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_empty(out_empty), .out_data(out_data), .out_err(out_err), .pop(pop)
    );
endmodule

// File: rtl/ptf_checker.sv
module ptf_checker #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             almost_full,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic             out_err,
    input logic [CNT_W-1:0] fill,
    input logic [CNT_W-1:0] eop_cnt,
    input logic [CNT_W-1:0] start_lvl
);
    // R5
    throttle_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        almost_full |-> !in_ready);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    // R7
    abort_closes_packet_chk: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_valid && out_eop));

    // R2
    saf_waits_for_eop_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop && !out_err && start_lvl == '0) |-> (eop_cnt != '0));

    // R3
    cut_through_level_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop && eop_cnt == '0 && start_lvl != '0) |-> (fill >= start_lvl));
endmodule

bind pkt_tx_fifo ptf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .in_ready(in_ready), .almost_full(almost_full),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
    .fill(fill_cnt), .eop_cnt(eop_cnt), .start_lvl(start_lvl)
);

// File: tb/pkt_tx_fifo_tb.sv
module pkt_tx_fifo_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        cfg_we = 0;
    logic [1:0]  cfg_a  = 0;
    logic [6:0]  cfg_d  = 0;
    logic        iv = 0, isop = 0, ieop = 0;
    logic [1:0]  iemp = 0;
    logic [31:0] idat = 0;
    logic        ir, af, sw, ov, osop, oeop, oerr;
    logic        ordy = 0;
    logic [1:0]  oemp;
    logic [31:0] odat;

    pkt_tx_fifo #(.DEPTH(64), .READY_LAT(0)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_we), .cfg_wr_addr(cfg_a), .cfg_wr_data(cfg_d),
        .in_valid(iv), .in_ready(ir), .in_sop(isop), .in_eop(ieop), .in_empty(iemp),
        .in_data(idat), .almost_full(af), .space_warn(sw), .out_valid(ov), .out_ready(ordy),
        .out_sop(osop), .out_eop(oeop), .out_empty(oemp), .out_data(odat), .out_err(oerr)
    );

    // second instance with ready latency one
    logic        cfg_we1 = 0;
    logic [1:0]  cfg_a1  = 0;
    logic [6:0]  cfg_d1  = 0;
    logic        iv1 = 0;
    logic        ir1, af1, sw1, ov1, osop1, oeop1, oerr1;
    logic [1:0]  oemp1;
    logic [31:0] odat1;

    pkt_tx_fifo #(.DEPTH(64), .READY_LAT(1)) dut_l1_i (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_we1), .cfg_wr_addr(cfg_a1), .cfg_wr_data(cfg_d1),
        .in_valid(iv1), .in_ready(ir1), .in_sop(1'b0), .in_eop(1'b0), .in_empty(2'b00),
        .in_data(32'h5), .almost_full(af1), .space_warn(sw1), .out_valid(ov1), .out_ready(1'b0),
        .out_sop(osop1), .out_eop(oeop1), .out_empty(oemp1), .out_data(odat1), .out_err(oerr1)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg(input logic [1:0] a, input logic [6:0] d);
        cfg_we = 1; cfg_a = a; cfg_d = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic push(input logic s, input logic e, input logic [1:0] m, input logic [31:0] d);
        iv = 1; isop = s; ieop = e; iemp = m; idat = d;
        @(negedge clk);
    endtask

    task automatic in_idle();
        iv = 0; isop = 0; ieop = 0; iemp = 0; idat = 0;
    endtask

    task automatic take_beat(input string req, input logic s, input logic e,
                             input logic [1:0] m, input logic [31:0] d, input logic er);
        #1;
        check(req, {63'd0, ov}, 64'd1);
        check(req, {60'd0, osop, oeop, oemp}, {60'd0, s, e, m});
        check(req, {63'd0, oerr}, {63'd0, er});
        check(req, {32'd0, odat}, {32'd0, d});
        ordy = 1;
        @(negedge clk);
        ordy = 0;
    endtask

    task automatic do_reset();
        in_idle();
        ordy = 0;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [3:0]  len;
        logic [1:0]  emp;
        logic [6:0]  start;
        logic [31:0] base;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{4'd1, 2'd3, 7'd0,  32'hA000_0000},
        '{4'd4, 2'd0, 7'd16, 32'hB000_0010},
        '{4'd5, 2'd1, 7'd0,  32'hC000_0020},
        '{4'd7, 2'd2, 7'd3,  32'hD000_0030},
        '{4'd3, 2'd0, 7'd2,  32'hE000_0040}
    };

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        #1;
        check("R1", {59'd0, ov, oerr, af, sw, ir}, 64'd1);
        @(negedge clk);

        // R11 level write takes effect after the write edge
        cfg_we = 1; cfg_a = 2'd2; cfg_d = 7'd65;
        #1 check("R11 before edge", {63'd0, sw}, 64'd0);
        @(negedge clk);
        cfg_we = 0;
        #1 check("R11 after edge", {63'd0, sw}, 64'd1);
        cfg(2'd2, 7'd48);
        #1 check("R11 restore", {63'd0, sw}, 64'd0);

        // R4 table of packets written whole, then read
        for (int v = 0; v < 5; v++) begin
            cfg(2'd0, VECS[v].start);
            for (int w = 0; w < int'(VECS[v].len); w++)
                push(w == 0, w == int'(VECS[v].len) - 1,
                     (w == int'(VECS[v].len) - 1) ? VECS[v].emp : 2'd0, VECS[v].base + 32'(w));
            in_idle();
            @(negedge clk);
            for (int w = 0; w < int'(VECS[v].len); w++)
                take_beat("R4", w == 0, w == int'(VECS[v].len) - 1,
                          (w == int'(VECS[v].len) - 1) ? VECS[v].emp : 2'd0,
                          VECS[v].base + 32'(w), 1'b0);
        end

        // R10 back to back packets
        cfg(2'd0, 7'd0);
        push(1, 0, 0, 32'h11); push(0, 1, 1, 32'h12);
        push(1, 0, 0, 32'h21); push(0, 0, 0, 32'h22); push(0, 1, 2, 32'h23);
        in_idle();
        @(negedge clk);
        take_beat("R10", 1, 0, 0, 32'h11, 0); take_beat("R10", 0, 1, 1, 32'h12, 0);
        take_beat("R10", 1, 0, 0, 32'h21, 0); take_beat("R10", 0, 0, 0, 32'h22, 0);
        take_beat("R10", 0, 1, 2, 32'h23, 0);

        // R2 store-and-forward waits for eop
        push(1, 0, 0, 32'h31); push(0, 0, 0, 32'h32); push(0, 0, 0, 32'h33);
        in_idle();
        #1 check("R2 no eop yet", {63'd0, ov}, 64'd0);
        push(0, 1, 3, 32'h34);
        in_idle();
        take_beat("R2", 1, 0, 0, 32'h31, 0); take_beat("R2", 0, 0, 0, 32'h32, 0);
        take_beat("R2", 0, 0, 0, 32'h33, 0); take_beat("R2", 0, 1, 3, 32'h34, 0);

        // R3 cut-through start at the level
        cfg(2'd0, 7'd5); cfg(2'd3, 7'd2);
        for (int w = 0; w < 4; w++) push(w == 0, 0, 0, 32'h40 + 32'(w));
        in_idle();
        #1 check("R3 below level", {63'd0, ov}, 64'd0);
        push(0, 0, 0, 32'h44);
        in_idle();
        #1 check("R3 at level", {62'd0, ov, osop}, 64'd3);
        push(0, 1, 0, 32'h45);
        in_idle();
        for (int w = 0; w < 6; w++)
            take_beat("R3", w == 0, w == 5, 0, 32'h40 + 32'(w), 0);

        // R7 abort when the packet runs dry
        cfg(2'd0, 7'd6); cfg(2'd3, 7'd3);
        for (int w = 0; w < 6; w++) push(w == 0, 0, 0, 32'h50 + 32'(w));
        in_idle();
        take_beat("R7", 1, 0, 0, 32'h50, 0); take_beat("R7", 0, 0, 0, 32'h51, 0);
        take_beat("R7", 0, 0, 0, 32'h52, 0); take_beat("R7 abort beat", 0, 1, 0, 32'h53, 1);
        repeat (3) @(negedge clk);
        #1 check("R7 rest dropped", {63'd0, ov}, 64'd0);
        push(0, 0, 0, 32'h56); push(0, 0, 0, 32'h57); push(0, 1, 0, 32'h58);
        in_idle();
        repeat (2) @(negedge clk);
        #1 check("R7 tail dropped", {63'd0, ov}, 64'd0);
        push(1, 0, 0, 32'h61); push(0, 1, 1, 32'h62);
        in_idle();
        take_beat("R7 next packet", 1, 0, 0, 32'h61, 0);
        take_beat("R7 next packet", 0, 1, 1, 32'h62, 0);

        // R8 start level not above abort level
        cfg(2'd0, 7'd2); cfg(2'd3, 7'd8);
        push(1, 0, 0, 32'h71); push(0, 0, 0, 32'h72);
        in_idle();
        #1 check("R8", {60'd0, ov, osop, oeop, oerr}, 64'hF);
        do_reset();

        // R5 / R6 throttle and warning, defaults after reset
        cfg(2'd0, 7'd0);
        for (int w = 0; w < 16; w++) push(w == 0, 0, 0, 32'(w));
        in_idle();
        #1 check("R6 free 48", {63'd0, sw}, 64'd0);
        push(0, 0, 0, 32'h100);
        in_idle();
        #1 check("R6 free 47", {63'd0, sw}, 64'd1);
        for (int w = 17; w < 60; w++) push(0, 0, 0, 32'(w));
        in_idle();
        #1 check("R5 free 4", {62'd0, ir, af}, 64'd2);
        push(0, 0, 0, 32'h200);
        in_idle();
        #1 check("R5 free 3", {62'd0, ir, af}, 64'd1);
        push(0, 1, 0, 32'h300);
        in_idle();
        @(negedge clk);
        #1 check("R5 write ignored", {63'd0, ov}, 64'd0);
        do_reset();
        #1 check("R1 after refill", {59'd0, ov, oerr, af, sw, ir}, 64'd1);

        // R9 ready latency one
        cfg_we1 = 1; cfg_a1 = 2'd1; cfg_d1 = 7'd62;
        @(negedge clk);
        cfg_a1 = 2'd0; cfg_d1 = 7'd3;
        @(negedge clk);
        cfg_we1 = 0;
        iv1 = 1;
        repeat (4) @(negedge clk);
        iv1 = 0;
        #1 check("R9 three stored", {62'd0, ov1, ir1}, 64'd2);
        cfg_we1 = 1; cfg_a1 = 2'd0; cfg_d1 = 7'd4;
        @(negedge clk);
        cfg_we1 = 0;
        #1 check("R9 not four", {63'd0, ov1}, 64'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule